// File: doc/BRIEF.md
# 8-bit Arithmetic/Logic Unit with Status Flags

This block performs the data operations of a small 8-bit RISC core: addition and subtraction with or without an incoming carry, comparison, bitwise logic, inversion and negation, increment and decrement, single-bit shifts and rotates, and a nibble exchange. Each operation takes a destination operand, a source operand (either a register value or an immediate chosen by a select pin) and the current 8-bit status byte. It returns a result, an updated status byte in which only the flags that belong to that operation change, and a flag telling the register file whether the result is to be written back.

Operations arrive on a valid/ready stream and the computed result leaves on a second valid/ready stream through a single output register. An operation is taken when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle, so a stalled consumer (`out_ready` low while `out_valid` is high) stops new operations from entering. While stalled, the result, status and write-back outputs hold steady. A producer must keep its operation stable while `in_valid` is high and `in_ready` is low.

Top module: `alu8_core`

## Requirements
- R1: The status byte has I at bit 7, T at bit 6, H at bit 5, S at bit 4, V at bit 3, N at bit 2, Z at bit 1 and C at bit 0; I and T come out equal to their input value for every operation. Operation codes on `in_op`: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 compare, 5 compare with carry, 6 and, 7 or, 8 exclusive or, 9 invert, 10 negate, 11 increment, 12 decrement, 13 logical shift right, 14 arithmetic shift right, 15 rotate left through carry, 16 rotate right through carry, 17 swap nibbles.
- R2: Add (d + s) and add with carry (d + s + C) update C as the carry out of bit 7, H as the carry out of bit 3, V as signed overflow, N as result bit 7 and Z as result equal to zero.
- R3: Subtract (d − s) and subtract with carry (d − s − C) update C as the borrow out of bit 7, H as the borrow out of bit 3, V as signed overflow, and N and Z from the result.
- R4: For subtract with carry and compare with carry, Z is 1 only when the result is zero and the incoming Z was 1.
- R5: Compare (d − s) and compare with carry (d − s − C) update flags exactly as the matching subtract but drive the write-back flag low; every other listed operation drives it high.
- R6: Increment and decrement update only Z, N and V (V set only when incrementing 0x7F or decrementing 0x80); C and H are unchanged.
- R7: And, or and exclusive or update Z and N, force V to 0 and leave C and H unchanged.
- R8: Invert gives 0xFF − d with C forced to 1 and V to 0, H unchanged; negate gives 0x00 − d with C = (d ≠ 0), V = (d = 0x80), H = (low nibble of d ≠ 0).
- R9: Logical shift right moves 0 into bit 7, arithmetic shift right keeps bit 7, rotate right moves C into bit 7, and all three move bit 0 into C; rotate left moves C into bit 0 and bit 7 into C. Shifts set N from result bit 7, Z from the result, V = N xor C, and leave H unchanged.
- R10: Swap exchanges the two nibbles of d and returns the status byte unchanged.
- R11: For every operation except swap, the output S equals output N xor output V.
- R12: When `in_imm_sel` is 1 the source operand is `in_imm`, otherwise `in_rr`.
- R13: After reset `out_valid` is 0 and `in_ready` is 1; results leave in the order operations were taken, and while `out_valid` is 1 and `out_ready` is 0 the outputs hold and no operation is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Block can take an operation this cycle |
| in_op | input | 5 | Operation code (see R1) |
| in_rd | input | 8 | Destination operand |
| in_rr | input | 8 | Register source operand |
| in_imm | input | 8 | Immediate source operand |
| in_imm_sel | input | 1 | 1 selects the immediate as source |
| in_sreg | input | 8 | Incoming status byte |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_res | output | 8 | Computed result |
| out_sreg | output | 8 | Updated status byte |
| out_wb | output | 1 | Result is to be written back |

## Verification
Two things can coincide in one cycle: the consumer draining the held result and the producer handing over a new operation, and a new operation being presented while the held result is stalled. The bench alternates between a phase with the consumer always ready and a phase where `out_ready` drops at random, so both the back-to-back handover and the blocked handover occur many times. A scoreboard queues the expected result, status and write-back flag at each accepted operation and compares them in order at each drained result, so a lost, duplicated or overwritten result shows up as a mismatch.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_ADDC  = 5'd1,
    OP_SUB   = 5'd2,
    OP_SUBC  = 5'd3,
    OP_CMP   = 5'd4,
    OP_CMPC  = 5'd5,
    OP_AND   = 5'd6,
    OP_OR    = 5'd7,
    OP_XOR   = 5'd8,
    OP_INV   = 5'd9,
    OP_NEG   = 5'd10,
    OP_INC   = 5'd11,
    OP_DEC   = 5'd12,
    OP_SHR   = 5'd13,
    OP_SAR   = 5'd14,
    OP_RLC   = 5'd15,
    OP_RRC   = 5'd16,
    OP_SWAPN = 5'd17
  } op_e;

  localparam int OP_W = 5;
  localparam int SR_W = 8;

  // status bit positions; a neighbouring branch unit decodes these
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int FL_T = 6;
  localparam int FL_I = 7;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  input  logic              ci,
  input  logic              sub,
  output logic [DATA_W-1:0] res,
  output logic              c_out,
  output logic              h_out,
  output logic              v_out
);
  localparam int HALF = DATA_W / 2;
  localparam int MSB  = DATA_W - 1;

  logic [DATA_W-1:0] yy;
  logic              cc;
  logic [HALF:0]     lo;
  logic [DATA_W:0]   full;

  always_comb begin
    // subtraction as x + ~y + ~borrow; carries become borrows by inversion
    yy    = sub ? ~y : y;
    cc    = sub ? ~ci : ci;
    lo    = {1'b0, x[HALF-1:0]} + {1'b0, yy[HALF-1:0]} + {{HALF{1'b0}}, cc};
    full  = {1'b0, x} + {1'b0, yy} + {{DATA_W{1'b0}}, cc};
    res   = full[DATA_W-1:0];
    c_out = full[DATA_W] ^ sub;
    h_out = lo[HALF] ^ sub;
    v_out = (x[MSB] == yy[MSB]) && (full[MSB] != x[MSB]);
  end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              ci,
  output logic [DATA_W-1:0] res,
  output logic              c_out
);
  localparam int HALF = DATA_W / 2;
  localparam int MSB  = DATA_W - 1;

  always_comb begin
    res   = a;
    c_out = ci;
    unique case (op)
      OP_AND:   res = a & b;
      OP_OR:    res = a | b;
      OP_XOR:   res = a ^ b;
      OP_INV:   begin res = ~a; c_out = 1'b1; end
      OP_SHR:   begin res = {1'b0,   a[MSB:1]}; c_out = a[0];   end
      OP_SAR:   begin res = {a[MSB], a[MSB:1]}; c_out = a[0];   end
      OP_RRC:   begin res = {ci,     a[MSB:1]}; c_out = a[0];   end
      OP_RLC:   begin res = {a[MSB-1:0], ci};   c_out = a[MSB]; end
      OP_SWAPN: res = {a[HALF-1:0], a[DATA_W-1:HALF]};
      default:  ;
    endcase
  end

endmodule

// File: rtl/alu8_exec.sv
module alu8_exec
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [SR_W-1:0]   sr_in,
  output logic [DATA_W-1:0] res,
  output logic [SR_W-1:0]   sr_out,
  output logic              wb
);
  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] ONE  = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] ZERO = '0;

  logic [DATA_W-1:0] as_x, as_y, as_res, bo_res;
  logic              as_ci, as_sub, as_c, as_h, as_v, bo_c;
  logic              grp_arith, grp_step, grp_logic, grp_shift, known;

  always_comb begin
    as_x = a; as_y = b; as_sub = 1'b0; as_ci = 1'b0;
    unique case (op)
      OP_ADDC:               as_ci = sr_in[FL_C];
      OP_SUB, OP_CMP:        as_sub = 1'b1;
      OP_SUBC, OP_CMPC:      begin as_sub = 1'b1; as_ci = sr_in[FL_C]; end
      OP_NEG:                begin as_sub = 1'b1; as_x = ZERO; as_y = a; end
      OP_INC:                as_y = ONE;
      OP_DEC:                begin as_sub = 1'b1; as_y = ONE; end
      default:               ;
    endcase
  end

  alu8_addsub #(.DATA_W(DATA_W)) u_as (
    .x(as_x), .y(as_y), .ci(as_ci), .sub(as_sub),
    .res(as_res), .c_out(as_c), .h_out(as_h), .v_out(as_v)
  );

  alu8_bitops #(.DATA_W(DATA_W)) u_bo (
    .op(op), .a(a), .b(b), .ci(sr_in[FL_C]), .res(bo_res), .c_out(bo_c)
  );

  always_comb begin
    grp_arith = op inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP, OP_CMPC, OP_NEG};
    grp_step  = op inside {OP_INC, OP_DEC};
    grp_logic = op inside {OP_AND, OP_OR, OP_XOR, OP_INV};
    grp_shift = op inside {OP_SHR, OP_SAR, OP_RLC, OP_RRC};
    known     = grp_arith || grp_step || grp_logic || grp_shift || (op == OP_SWAPN);

    res    = (grp_arith || grp_step) ? as_res : bo_res;
    sr_out = sr_in;
    wb     = known && !(op inside {OP_CMP, OP_CMPC});

    if (grp_arith || grp_step || grp_logic || grp_shift) begin
      sr_out[FL_N] = res[MSB];
      sr_out[FL_Z] = (res == ZERO);
    end
    if (grp_arith) begin
      sr_out[FL_C] = as_c;
      sr_out[FL_H] = as_h;
      sr_out[FL_V] = as_v;
      // carry-chained subtract keeps a cleared Z cleared across bytes
      if (op inside {OP_SUBC, OP_CMPC})
        sr_out[FL_Z] = (res == ZERO) && sr_in[FL_Z];
    end
    if (grp_step)  sr_out[FL_V] = as_v;
    if (grp_logic) begin
      sr_out[FL_V] = 1'b0;
      sr_out[FL_C] = bo_c;
    end
    if (grp_shift) begin
      sr_out[FL_C] = bo_c;
      sr_out[FL_V] = res[MSB] ^ bo_c;
    end
    if (grp_arith || grp_step || grp_logic || grp_shift)
      sr_out[FL_S] = sr_out[FL_N] ^ sr_out[FL_V];
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [DATA_W-1:0] in_rd,
  input  logic [DATA_W-1:0] in_rr,
  input  logic [DATA_W-1:0] in_imm,
  input  logic              in_imm_sel,
  input  logic [SR_W-1:0]   in_sreg,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_res,
  output logic [SR_W-1:0]   out_sreg,
  output logic              out_wb
);
  op_e               op;
  logic [DATA_W-1:0] src_b, nx_res;
  logic [SR_W-1:0]   nx_sr;
  logic              nx_wb, take;

  assign op       = op_e'(in_op);
  assign src_b    = in_imm_sel ? in_imm : in_rr;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  alu8_exec #(.DATA_W(DATA_W)) u_exec (
    .op(op), .a(in_rd), .b(src_b), .sr_in(in_sreg),
    .res(nx_res), .sr_out(nx_sr), .wb(nx_wb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_sreg  <= '0;
      out_wb    <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_res   <= nx_res;
      out_sreg  <= nx_sr;
      out_wb    <= nx_wb;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R13: a stalled result stays put
  a_r13_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_sreg) && $stable(out_wb));

  // R1: interrupt and transfer bits pass through
  a_r1_it_pass: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_sreg[FL_I:FL_T] == $past(in_sreg[FL_I:FL_T]));

  // R5: compares never request write-back
  a_r5_cmp_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    take && (in_op == OP_CMP || in_op == OP_CMPC) |=> !out_wb);

  // R10: swap leaves the status byte alone
  a_r10_swap_flags: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == OP_SWAPN |=> out_sreg == $past(in_sreg));

  // R11: signed condition at the output
  a_r11_s_matches: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op != OP_SWAPN && in_op <= OP_SWAPN |=>
      out_sreg[FL_S] == (out_sreg[FL_N] ^ out_sreg[FL_V]));

endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
  typedef struct {
    logic [7:0] res;
    logic [7:0] sr;
    logic       wb;
    string      tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_imm_sel = 1'b0, out_ready = 1'b1;
  logic [4:0] in_op = '0;
  logic [7:0] in_rd = '0, in_rr = '0, in_imm = '0, in_sreg = '0;
  logic in_ready, out_valid, out_wb;
  logic [7:0] out_res, out_sreg;

  int n_cmp = 0, n_bad = 0;
  bit bp_mode = 1'b0, done = 1'b0;
  exp_t q[$];

  always #5 clk = ~clk;

  alu8_core u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rd(in_rd), .in_rr(in_rr), .in_imm(in_imm),
    .in_imm_sel(in_imm_sel), .in_sreg(in_sreg), .out_valid(out_valid),
    .out_ready(out_ready), .out_res(out_res), .out_sreg(out_sreg), .out_wb(out_wb)
  );

  function automatic int sgn(logic [7:0] v);
    return v[7] ? int'(v) - 256 : int'(v);
  endfunction

  // independent reference built from the requirement text
  function automatic exp_t model(int op, logic [7:0] a, logic [7:0] b, logic [7:0] si);
    exp_t e;
    logic c, z, n, v, h, s;
    int t, sv, ci;
    logic [7:0] r;
    c = si[0]; z = si[1]; n = si[2]; v = si[3]; s = si[4]; h = si[5];
    r = a; e.wb = 1'b1;
    ci = ((op == 1 || op == 3 || op == 5) && c) ? 1 : 0;
    case (op)
      0, 1: begin
        t = int'(a) + int'(b) + ci; r = t[7:0]; c = t > 255;
        h = (int'(a[3:0]) + int'(b[3:0]) + ci) > 15;
        sv = sgn(a) + sgn(b) + ci; v = sv > 127 || sv < -128;
      end
      2, 3, 4, 5: begin
        t = int'(a) - int'(b) - ci; r = t[7:0]; c = t < 0;
        h = (int'(a[3:0]) - int'(b[3:0]) - ci) < 0;
        sv = sgn(a) - sgn(b) - ci; v = sv > 127 || sv < -128;
        if (op == 4 || op == 5) e.wb = 1'b0;
      end
      6: begin r = a & b; v = 0; end
      7: begin r = a | b; v = 0; end
      8: begin r = a ^ b; v = 0; end
      9: begin r = 8'hFF - a; v = 0; c = 1; end
      10: begin r = 8'h00 - a; c = a != 0; v = a == 8'h80; h = a[3:0] != 0; end
      11: begin r = a + 8'd1; v = a == 8'h7F; end
      12: begin r = a - 8'd1; v = a == 8'h80; end
      13: begin r = a >> 1; c = a[0]; end
      14: begin r = {a[7], a[7:1]}; c = a[0]; end
      15: begin r = {a[6:0], si[0]}; c = a[7]; end
      16: begin r = {si[0], a[7:1]}; c = a[0]; end
      default: r = {a[3:0], a[7:4]};
    endcase
    if (op != 17) begin
      n = r[7];
      z = (r == 0);
      if (op == 3 || op == 5) z = z && si[1];
      if (op >= 13 && op <= 16) v = n ^ c;
      s = n ^ v;
    end
    e.res = r;
    e.sr  = {si[7:6], h, s, v, n, z, c};
    return e;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(int op, logic [7:0] d, logic [7:0] r, logic [7:0] im,
                       logic sel, logic [7:0] sr, string tag);
    exp_t e;
    @(negedge clk);
    in_op = op[4:0]; in_rd = d; in_rr = r; in_imm = im; in_imm_sel = sel; in_sreg = sr;
    in_valid = 1'b1;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    e = model(op, d, sel ? im : r, sr);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: picks consumer readiness, then compares a drained result
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      out_ready = bp_mode ? ($urandom_range(0, 3) != 0) : 1'b1;
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R13 unexpected result actual=%0h expected=none", out_res);
        end else begin
          e = q.pop_front();
          chk({e.tag, " result"}, 32'(out_res), 32'(e.res));
          chk({e.tag, " status"}, 32'(out_sreg), 32'(e.sr));
          chk({e.tag, " writeback"}, 32'(out_wb), 32'(e.wb));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R13 watchdog actual=hung expected=complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R13 reset out_valid", 32'(out_valid), 32'd0);
    chk("R13 reset in_ready", 32'(in_ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 add corners
    drive(0, 8'h7F, 8'h01, 8'h00, 1'b0, 8'hC0, "R2 add overflow");
    drive(0, 8'hFF, 8'h01, 8'h00, 1'b0, 8'h00, "R2 add carry zero");
    drive(1, 8'h0E, 8'h01, 8'h00, 1'b0, 8'h01, "R2 adc half");
    // R3 subtract corners
    drive(2, 8'h00, 8'h01, 8'h00, 1'b0, 8'h00, "R3 sub borrow");
    drive(2, 8'h80, 8'h01, 8'h00, 1'b0, 8'h00, "R3 sub overflow");
    drive(3, 8'h10, 8'h0F, 8'h00, 1'b0, 8'h01, "R3 sbc zero");
    // R4 sticky Z
    drive(3, 8'h05, 8'h04, 8'h00, 1'b0, 8'h01, "R4 sbc zero keeps Z clear");
    drive(3, 8'h05, 8'h04, 8'h00, 1'b0, 8'h03, "R4 sbc zero with Z set");
    drive(5, 8'h22, 8'h21, 8'h00, 1'b0, 8'h01, "R4 cpc zero keeps Z clear");
    // R5 compares
    drive(4, 8'h33, 8'h33, 8'h00, 1'b0, 8'h00, "R5 cp equal");
    drive(4, 8'h01, 8'h00, 8'h02, 1'b1, 8'h00, "R5 cp immediate");
    // R6 increment/decrement
    drive(11, 8'h7F, 8'h00, 8'h00, 1'b0, 8'h21, "R6 inc overflow keeps C H");
    drive(12, 8'h80, 8'h00, 8'h00, 1'b0, 8'h01, "R6 dec overflow");
    drive(12, 8'h01, 8'h00, 8'h00, 1'b0, 8'h20, "R6 dec to zero");
    // R7 logic
    drive(6, 8'hF0, 8'h3C, 8'h00, 1'b0, 8'h29, "R7 and clears V");
    drive(8, 8'hAA, 8'hAA, 8'h00, 1'b0, 8'h08, "R7 xor zero");
    drive(7, 8'h00, 8'h00, 8'h81, 1'b1, 8'h00, "R12 or immediate");
    // R8 invert/negate
    drive(9, 8'h00, 8'h00, 8'h00, 1'b0, 8'h28, "R8 invert");
    drive(10, 8'h80, 8'h00, 8'h00, 1'b0, 8'h00, "R8 negate min");
    drive(10, 8'h00, 8'h00, 8'h00, 1'b0, 8'h3F, "R8 negate zero");
    drive(10, 8'h10, 8'h00, 8'h00, 1'b0, 8'h00, "R8 negate nibble");
    // R9 shifts
    drive(13, 8'h81, 8'h00, 8'h00, 1'b0, 8'h20, "R9 shr");
    drive(14, 8'h81, 8'h00, 8'h00, 1'b0, 8'h00, "R9 sar");
    drive(15, 8'h80, 8'h00, 8'h00, 1'b0, 8'h00, "R9 rlc to zero");
    drive(16, 8'h02, 8'h00, 8'h00, 1'b0, 8'h01, "R9 rrc carry in");
    // R10 swap
    drive(17, 8'h3C, 8'h00, 8'h00, 1'b0, 8'h5A, "R10 swap");
    idle();

    // R11/R13 random traffic, first free-flowing then with back-pressure
    for (int ph = 0; ph < 2; ph++) begin
      bp_mode = (ph == 1);
      for (int i = 0; i < 300; i++) begin
        drive(int'($urandom_range(0, 17)), 8'($urandom), 8'($urandom), 8'($urandom),
              1'($urandom), 8'($urandom), "R11 R13 random");
        if ($urandom_range(0, 4) == 0) idle();
      end
      idle();
    end
    bp_mode = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R13 drained out_valid", 32'(out_valid), 32'd0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule